// File: doc/BRIEF.md
# Work queue entry posting engine

This block builds one variable-length work descriptor per request and writes it, one 32-bit word per cycle, into a circular work-queue buffer. The buffer is managed in 32-byte units. A head counter, kept inside the block, and a tail counter, supplied from outside, both count units and are never masked. A request carries a scatter-gather element count, an inline side-band length and up to 24 bytes of inline data, a client data unit value, and the scatter-gather elements themselves.

On acceptance the block sizes the descriptor and compares it with the free space in the queue. If it fits, the block streams a two-dword header, a zero-padded inline region and the element list to a valid/ready write port. Every word lands at an address taken modulo the buffer size, so a descriptor that runs past the end of the buffer continues at its start. When the last word is taken, the block pulses `done`, advances the head and reports where the entry was placed. If the descriptor does not fit, the block pulses `done` with `done_busy` set, and it writes nothing.

Top module: `wqe_post_engine`

## Requirements
- R1: After reset, `head` is 0, `req_ready` is 1, and `wr_valid`, `done` and `done_busy` are 0.
- R2: The descriptor size in units is ceil((8 + inline region + 16 × max(1, element count)) / 32). It is reported on `rpt_units`.
- R3: The inline region is 8 bytes when `req_oob_len` ≤ 8 and 24 bytes otherwise. Its word j carries `req_oob_data` bytes 4j..4j+3, least significant byte first. Any byte whose index is at or beyond `req_oob_len` is written as zero.
- R4: Header word 0 is all zero. Header word 1 holds the element count in bits 7:0, the inline region size in dwords (2 or 6) in bits 10:8, and `req_cdu` in bits 29:16. All other bits are 0.
- R5: Element e is taken from `req_sge[128e +: 128]`, with the address in bits 63:0, the key in bits 95:64 and the size in bits 127:96. It is written as four words: address low, address high, key, size.
- R6: A request with zero elements writes exactly one element, with address 1, key 0 and size 0. The count field of the header stays 0.
- R7: Word k of a descriptor posted at head h is written at byte address (32·h + 4k) mod BUF_BYTES. This wraps the descriptor across the buffer end.
- R8: Free units are BUF_BYTES/32 − (head − tail). A request larger than the free space is rejected with `done` and `done_busy` one cycle later, no write and `head` unchanged. A request exactly equal to the free space is accepted.
- R9: On success, `head` rises by the size in units in the same cycle that `done` rises. `rpt_head` is the head before the advance, and `rpt_index` is that head modulo BUF_BYTES/32.
- R10: A descriptor is exactly 2 + inline/4 + 4·max(1, count) words. Address and data hold while `wr_valid` is high and `wr_ready` is low. `done` follows one cycle after the last word is taken.
- R11: A request is taken only while `req_ready` is high. `req_ready` stays low while a descriptor is being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Post request present |
| req_ready | output | 1 | Engine idle, request will be taken |
| req_sge_cnt | input | $clog2(MAX_SGE+1) | Number of scatter-gather elements |
| req_oob_len | input | 5 | Inline side-band byte count, 0..24 |
| req_oob_data | input | 192 | Inline side-band bytes, byte 0 in bits 7:0 |
| req_cdu | input | 14 | Client data unit value |
| req_sge | input | 128·MAX_SGE | Packed scatter-gather elements |
| tail | input | PTR_W | Consumer position in units |
| head | output | PTR_W | Producer position in units |
| wr_valid | output | 1 | Buffer write word valid |
| wr_ready | input | 1 | Buffer accepts the word |
| wr_addr | output | $clog2(BUF_BYTES) | Byte address of the word |
| wr_data | output | 32 | Word to write |
| done | output | 1 | One-cycle end-of-request pulse |
| done_busy | output | 1 | With done: request rejected for lack of space |
| rpt_index | output | $clog2(BUF_BYTES)-5 | Masked unit index of the entry |
| rpt_head | output | PTR_W | Unmasked head before the advance |
| rpt_units | output | $clog2((32+16·MAX_SGE+31)/32+1) | Entry size in units |

## Verification
The head advance that ends one post can coincide with the acceptance and free-space test of the next. The bench raises the next request in the very cycle `done` is high, so the space check must already see the advanced head. That is judged through the accept-or-reject outcome at queue-full boundaries (free space of 0, 1, 2 and 3 units), and through `rpt_head` and `rpt_index` of the following entry. A 3-unit descriptor posted at the last unit of the buffer, under a stalling `wr_ready` pattern, shows whether the wrap of word addresses and the hold of the write port interact correctly.

// File: rtl/wqe_post_engine.sv
module wqe_post_engine #(
  parameter int BUF_BYTES = 256,
  parameter int MAX_SGE   = 4,
  parameter int PTR_W     = 32,
  localparam int CNT_W    = $clog2(MAX_SGE + 1),
  localparam int AW       = $clog2(BUF_BYTES),
  localparam int IDX_W    = AW - 5,
  localparam int SGE_W    = 128 * MAX_SGE,
  localparam int MAX_UNITS = (32 + 16 * MAX_SGE + 31) / 32,
  localparam int U_W      = $clog2(MAX_UNITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CNT_W-1:0]  req_sge_cnt,
  input  logic [4:0]        req_oob_len,
  input  logic [191:0]      req_oob_data,
  input  logic [13:0]       req_cdu,
  input  logic [SGE_W-1:0]  req_sge,
  input  logic [PTR_W-1:0]  tail,
  output logic [PTR_W-1:0]  head,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [AW-1:0]     wr_addr,
  output logic [31:0]       wr_data,
  output logic              done,
  output logic              done_busy,
  output logic [IDX_W-1:0]  rpt_index,
  output logic [PTR_W-1:0]  rpt_head,
  output logic [U_W-1:0]    rpt_units
);
  localparam int Q_UNITS   = BUF_BYTES / 32;
  localparam int MAX_WORDS = 8 + 4 * MAX_SGE;
  localparam int K_W       = $clog2(MAX_WORDS + 1);

  logic              big_in;
  logic [CNT_W-1:0]  n_eff_in;
  logic [15:0]       desc_bytes;
  logic [U_W-1:0]    units_in;
  logic [PTR_W-1:0]  free_units;
  logic              fits;

  logic              writing;
  logic [K_W-1:0]    k;
  logic [K_W-1:0]    nwords;
  logic [AW-1:0]     base;
  logic              l_big;
  logic [CNT_W-1:0]  l_cnt;
  logic [4:0]        l_len;
  logic [191:0]      l_oob;
  logic [13:0]       l_cdu;
  logic [SGE_W-1:0]  l_sge;
  logic [U_W-1:0]    l_units;

  logic [2:0]        oob_dw;
  logic [15:0]       kk;
  logic [15:0]       jidx;
  logic [15:0]       sidx;
  logic [127:0]      elem;
  logic [31:0]       oob_word;

  assign big_in     = req_oob_len > 5'd8;
  assign n_eff_in   = (req_sge_cnt == '0) ? CNT_W'(1) : req_sge_cnt;
  assign desc_bytes = 16'd8 + (big_in ? 16'd24 : 16'd8) + 16'(n_eff_in) * 16'd16;
  assign units_in   = U_W'((desc_bytes + 16'd31) >> 5);
  assign free_units = PTR_W'(Q_UNITS) - (head - tail);
  assign fits       = PTR_W'(units_in) <= free_units;

  assign req_ready = !writing;
  assign wr_valid  = writing;
  assign wr_addr   = base + AW'({kk, 2'b00});

  assign oob_dw = l_big ? 3'd6 : 3'd2;
  assign kk     = 16'(k);
  assign jidx   = kk - 16'd2;
  assign sidx   = kk - 16'd2 - 16'(oob_dw);

  always_comb begin
    logic [191:0] sh;
    sh = l_oob >> {jidx, 5'b00000};
    oob_word = sh[31:0];
    for (int b = 0; b < 4; b++)
      if ({jidx[13:0], 2'b00} + 16'(b) >= 16'(l_len)) oob_word[8*b +: 8] = 8'h00;
  end

  always_comb begin
    logic [SGE_W-1:0] esh;
    esh = l_sge >> {sidx[15:2], 7'b0000000};
    if (l_cnt == '0) elem = {32'd0, 32'd0, 64'd1};
    else             elem = esh[127:0];
  end

  always_comb begin
    logic [127:0] wsh;
    wsh = elem >> {sidx[1:0], 5'b00000};
    if (k == '0)
      wr_data = 32'd0;
    else if (k == K_W'(1))
      wr_data = {2'b00, l_cdu, 5'b00000, oob_dw, 8'(l_cnt)};
    else if (kk < 16'd2 + 16'(oob_dw))
      wr_data = oob_word;
    else
      wr_data = wsh[31:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      writing   <= 1'b0;
      k         <= '0;
      nwords    <= '0;
      base      <= '0;
      l_big     <= 1'b0;
      l_cnt     <= '0;
      l_len     <= '0;
      l_oob     <= '0;
      l_cdu     <= '0;
      l_sge     <= '0;
      l_units   <= '0;
      head      <= '0;
      done      <= 1'b0;
      done_busy <= 1'b0;
      rpt_index <= '0;
      rpt_head  <= '0;
      rpt_units <= '0;
    end else begin
      done      <= 1'b0;
      done_busy <= 1'b0;
      if (!writing && req_valid) begin
        if (fits) begin
          writing   <= 1'b1;
          k         <= '0;
          nwords    <= K_W'(16'd2 + (big_in ? 16'd6 : 16'd2) + 16'(n_eff_in) * 16'd4);
          base      <= {head[IDX_W-1:0], 5'b00000};
          l_big     <= big_in;
          l_cnt     <= req_sge_cnt;
          l_len     <= req_oob_len;
          l_oob     <= req_oob_data;
          l_cdu     <= req_cdu;
          l_sge     <= req_sge;
          l_units   <= units_in;
          rpt_index <= head[IDX_W-1:0];
          rpt_head  <= head;
          rpt_units <= units_in;
        end else begin
          done      <= 1'b1;
          done_busy <= 1'b1;
        end
      end
      if (writing && wr_ready) begin
        if (k == nwords - K_W'(1)) begin
          writing <= 1'b0;
          done    <= 1'b1;
          head    <= head + PTR_W'(l_units);
        end else begin
          k <= k + K_W'(1);
        end
      end
    end
  end
endmodule

module wqe_post_engine_chk #(
  parameter int AW    = 8,
  parameter int PTR_W = 32,
  parameter int U_W   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [AW-1:0]    wr_addr,
  input logic [31:0]      wr_data,
  input logic             done,
  input logic             done_busy,
  input logic [PTR_W-1:0] head,
  input logic [U_W-1:0]   rpt_units
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_valid);

  p_reject_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_busy |-> !wr_valid && $stable(head));

  p_head_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_busy |-> head == $past(head) + PTR_W'(rpt_units));

  p_head_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(head));

  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && $past(wr_valid && wr_ready) |-> wr_addr == $past(wr_addr) + AW'(4));
endmodule

bind wqe_post_engine wqe_post_engine_chk #(.AW(AW), .PTR_W(PTR_W), .U_W(U_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .done_busy(done_busy),
  .head(head), .rpt_units(rpt_units));

// File: tb/test_wqe_post_engine.sv
module test_wqe_post_engine;
  localparam int BUF_BYTES = 256;
  localparam int MAX_SGE   = 4;
  localparam int MAX_WORDS = 8 + 4 * MAX_SGE;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [2:0]   req_sge_cnt = '0;
  logic [4:0]   req_oob_len = '0;
  logic [191:0] req_oob_data = '0;
  logic [13:0]  req_cdu = '0;
  logic [511:0] req_sge = '0;
  logic [31:0]  tail = '0;
  logic [31:0]  head;
  logic         wr_valid;
  logic         wr_ready = 1'b1;
  logic [7:0]   wr_addr;
  logic [31:0]  wr_data;
  logic         done;
  logic         done_busy;
  logic [2:0]   rpt_index;
  logic [31:0]  rpt_head;
  logic [1:0]   rpt_units;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [31:0] model_head = '0;

  always #10 clk = ~clk;

  wqe_post_engine #(.BUF_BYTES(BUF_BYTES), .MAX_SGE(MAX_SGE), .PTR_W(32)) i_wqe_post_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sge_cnt(req_sge_cnt), .req_oob_len(req_oob_len), .req_oob_data(req_oob_data),
    .req_cdu(req_cdu), .req_sge(req_sge), .tail(tail), .head(head),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .done_busy(done_busy), .rpt_index(rpt_index), .rpt_head(rpt_head),
    .rpt_units(rpt_units));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic post(input int n, input int len, input logic [31:0] tl, input bit exp_busy);
    logic [31:0]  ew [MAX_WORDS];
    logic [191:0] od;
    logic [511:0] sd;
    logic [13:0]  cdu;
    logic [7:0]   base;
    int ob, ne, nbytes, units, nw, widx;
    bit first;
    string tag;
    cdu = 14'(n * 1000 + len * 37 + 5);
    for (int b = 0; b < 24; b++) od[8*b +: 8] = 8'(b * 17 + len * 3 + 1);
    for (int e = 0; e < MAX_SGE; e++) begin
      sd[128*e +: 64]      = {32'hA000_0000 | 32'(e), 32'(model_head * 7 + 32'(e + len))};
      sd[128*e + 64 +: 32] = 32'h5000 + 32'(e + n);
      sd[128*e + 96 +: 32] = 32'(64 * (e + 1) + len);
    end
    ob = (len > 8) ? 24 : 8;
    ne = (n == 0) ? 1 : n;
    nbytes = 8 + ob + 16 * ne;
    units = (nbytes + 31) / 32;
    nw = 2 + ob / 4 + 4 * ne;
    ew[0] = 32'd0;
    ew[1] = {2'b00, cdu, 5'b00000, 3'(ob / 4), 8'(n)};
    for (int j = 0; j < ob / 4; j++)
      for (int b = 0; b < 4; b++)
        ew[2+j][8*b +: 8] = (4*j + b < len) ? od[8*(4*j + b) +: 8] : 8'h00;
    for (int e = 0; e < ne; e++)
      for (int p = 0; p < 4; p++)
        ew[2 + ob/4 + 4*e + p] = (n == 0) ? ((p == 0) ? 32'd1 : 32'd0) : sd[128*e + 32*p +: 32];
    base = 8'(model_head << 5);

    req_sge_cnt = 3'(n);
    req_oob_len = 5'(len);
    req_oob_data = od;
    req_cdu = cdu;
    req_sge = sd;
    tail = tl;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    first = 1'b1;
    widx = 0;
    forever begin
      if (done) break;
      if (first && !exp_busy) chk("R11 req_ready low while writing", {63'd0, req_ready}, 64'd0);
      first = 1'b0;
      if (wr_valid) begin
        wr_ready = (cyc % 4) != 2;
        cyc++;
        if (wr_ready) begin
          if (widx < nw) begin
            chk("R7 word address", 64'(wr_addr), 64'(8'(base + 8'(4 * widx))));
            if (widx < 2) tag = "R4 header word";
            else if (widx < 2 + ob / 4) tag = "R3 inline word";
            else if (n == 0) tag = "R6 dummy element word";
            else tag = "R5 element word";
            chk(tag, 64'(wr_data), 64'(ew[widx]));
          end
          widx++;
        end
      end
      @(negedge clk);
    end
    chk("R8 busy flag", {63'd0, done_busy}, {63'd0, exp_busy});
    if (exp_busy) begin
      chk("R8 no words on reject", 64'(widx), 64'd0);
      chk("R8 head unchanged on reject", 64'(head), 64'(model_head));
    end else begin
      chk("R10 word count", 64'(widx), 64'(nw));
      chk("R2 size in units", 64'(rpt_units), 64'(units));
      chk("R9 masked index", 64'(rpt_index), 64'(model_head % 8));
      chk("R9 unmasked head", 64'(rpt_head), 64'(model_head));
      chk("R9 head advance", 64'(head), 64'(model_head + 32'(units)));
      model_head = model_head + 32'(units);
    end
  endtask

  initial begin
    int lens [6];
    lens = '{0, 3, 8, 9, 16, 24};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 head after reset", 64'(head), 64'd0);
    chk("R1 req_ready after reset", {63'd0, req_ready}, 64'd1);
    chk("R1 wr_valid after reset", {63'd0, wr_valid}, 64'd0);
    chk("R1 done after reset", {62'd0, done, done_busy}, 64'd0);

    for (int n = 0; n <= MAX_SGE; n++)
      for (int li = 0; li < 6; li++)
        post(n, lens[li], model_head, 1'b0);

    while (model_head % 8 != 7) post(1, 0, model_head, 1'b0);
    post(4, 24, model_head, 1'b0);

    post(4, 24, model_head - 32'd7, 1'b1);
    post(2, 0,  model_head - 32'd6, 1'b0);
    post(1, 0,  model_head - 32'd8, 1'b1);
    post(4, 24, model_head - 32'd5, 1'b0);
    post(0, 9,  model_head - 32'd7, 1'b1);
    post(0, 9,  model_head - 32'd6, 1'b0);

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule